// File: doc/BRIEF.md
# Six-Instruction Single-Cycle Processor Core

This block is a 32-bit processor core that finishes every instruction in one clock cycle. It runs six operations: register add, register subtract, OR with a zero-extended immediate, load word, store word, and branch when two registers are equal. Inside the core are the program counter, a 32 x 32-bit register file, an immediate extender, an ALU and a control decoder. The decoder sets every datapath control from the opcode and, for register-type instructions, from the function field.

The core drives an instruction fetch address and receives the instruction word in the same cycle. It also drives a data memory address, write data and a write strobe, and receives load data in the same cycle. Both memories are outside the core. They return read data combinationally and store data on the rising clock edge. Because every access completes within its own cycle, these ports carry no valid/ready handshake and the core applies no back-pressure. A memory that needs wait states cannot be attached to this core.

Instruction fields: opcode [31:26], first source register [25:21], second source / immediate-form destination [20:16], register-form destination [15:11], function [5:0], immediate [15:0]. Bits [10:6] are not used.

Top module: `cpu6_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter is loaded with 0, so `imem_addr` reads 0 after that edge.
- R2: After any instruction other than a taken branch, the next fetch address is the current address plus 4.
- R3: Opcode 0x00 with function 0x21 writes rs+rt into register rd, and with function 0x23 writes rs-rt into rd, modulo 2^32.
- R4: Opcode 0x0D writes rs OR {16'b0, imm16} into register rt. The immediate is zero-extended.
- R5: Opcode 0x23 reads data memory at rs plus the sign-extended immediate, and writes the returned word into register rt.
- R6: Opcode 0x2B asserts `dmem_wen` with `dmem_addr` = rs + sign-extended immediate and `dmem_wdata` = rt, and writes no register. No other opcode asserts `dmem_wen`.
- R7: Opcode 0x04 with rs equal to rt sets the next address to PC+4+(sign-extended immediate << 2), including negative offsets. With rs not equal to rt, the next address is PC+4. The branch writes no register.
- R8: Register 0 always reads as zero, and a write that targets it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction being fetched (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata | output | 32 | Store data (second source register) |
| dmem_wen | output | 1 | Store strobe; memory writes on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |

## Verification
The bench loads an immediate with bit 15 set. A core that sign-extends the OR immediate stores 0xFFFF8008 instead of 0x00008008. It also loads through a negative offset, which a zero-extending load would send to the wrong address. A taken forward branch must skip two stores: a core that ignores the equality flag writes them and fetches the wrong address sequence. A self-loop with offset -1 catches a branch adder that drops the sign. The bench writes to register 0 and then stores register 0, so a core with a writable register 0 stores 0x1234 instead of zero. A reset in the middle of a run must return the fetch address to 0.

// File: rtl/cpu6_pkg.sv
package cpu6_pkg;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD    = 6'h21;
  localparam logic [5:0] FN_SUB    = 6'h23;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    dst_is_rd;
    logic    src_is_imm;
    logic    ext_signed;
    logic    mem_write;
    logic    wb_from_mem;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/cpu6_decode.sv
module cpu6_decode
  import cpu6_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);

  always_comb begin
    ctrl_o = '{reg_write: 1'b0, dst_is_rd: 1'b0, src_is_imm: 1'b0,
               ext_signed: 1'b0, mem_write: 1'b0, wb_from_mem: 1'b0,
               branch: 1'b0, alu_op: ALU_ADD};
    unique case (opcode_i)
      OPC_RTYPE: begin
        ctrl_o.dst_is_rd = 1'b1;
        if (funct_i == FN_ADD) begin
          ctrl_o.reg_write = 1'b1;
          ctrl_o.alu_op    = ALU_ADD;
        end else if (funct_i == FN_SUB) begin
          ctrl_o.reg_write = 1'b1;
          ctrl_o.alu_op    = ALU_SUB;
        end
      end
      OPC_ORI: begin
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.src_is_imm = 1'b1;
        ctrl_o.alu_op     = ALU_OR;
      end
      OPC_LW: begin
        ctrl_o.reg_write   = 1'b1;
        ctrl_o.src_is_imm  = 1'b1;
        ctrl_o.ext_signed  = 1'b1;
        ctrl_o.wb_from_mem = 1'b1;
      end
      OPC_SW: begin
        ctrl_o.src_is_imm = 1'b1;
        ctrl_o.ext_signed = 1'b1;
        ctrl_o.mem_write  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.ext_signed = 1'b1;
        ctrl_o.branch     = 1'b1;
        ctrl_o.alu_op     = ALU_SUB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cpu6_immext.sv
module cpu6_immext #(
  parameter int DW = 32
) (
  input  logic [15:0]   imm_i,
  input  logic          signed_i,
  output logic [DW-1:0] ext_o
);

  localparam int PAD = DW - 16;

  always_comb begin
    ext_o = {{PAD{signed_i & imm_i[15]}}, imm_i};
  end

endmodule

// File: rtl/cpu6_alu.sv
module cpu6_alu
  import cpu6_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_op_e       op_i,
  output logic [DW-1:0] y_o,
  output logic          zero_o
);

  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_OR:  y_o = a_i | b_i;
      default: y_o = a_i + b_i;
    endcase
    zero_o = (y_o == '0);
  end

endmodule

// File: rtl/cpu6_regfile.sv
module cpu6_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(NREG)-1:0] raddr_a_i,
  input  logic [$clog2(NREG)-1:0] raddr_b_i,
  output logic [DW-1:0]           rdata_a_o,
  output logic [DW-1:0]           rdata_b_o,
  input  logic                    we_i,
  input  logic [$clog2(NREG)-1:0] waddr_i,
  input  logic [DW-1:0]           wdata_i
);

  localparam int AW = $clog2(NREG);

  logic [NREG-1:0][DW-1:0] bank;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign bank[g] = '0;
    end else begin : g_store
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (we_i && waddr_i == AW'(g)) q <= wdata_i;
      end
      assign bank[g] = q;
    end
  end

  assign rdata_a_o = bank[raddr_a_i];
  assign rdata_b_o = bank[raddr_b_i];

  // R3: a write to a nonzero register is visible after the edge
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
    (we_i && waddr_i != '0) |=> (bank[$past(waddr_i)] == $past(wdata_i)));

  // R8: register 0 keeps reading zero even right after a write aimed at it
  assert_zero_reg_R8: assert property (@(posedge clk) disable iff (rst)
    (we_i && waddr_i == '0) |=> (bank[0] == '0));

endmodule

// File: rtl/cpu6_core.sv
module cpu6_core
  import cpu6_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 32
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] imem_addr,
  input  logic [31:0]   imem_rdata,
  output logic [DW-1:0] dmem_addr,
  output logic [DW-1:0] dmem_wdata,
  output logic          dmem_wen,
  input  logic [DW-1:0] dmem_rdata
);

  localparam int AW = $clog2(NREG);

  logic [DW-1:0] pc_q, pc_plus4, br_target, pc_next;
  logic [5:0]    f_op, f_fn;
  logic [AW-1:0] f_rs, f_rt, f_rd, dst;
  logic [15:0]   f_imm;
  ctrl_t         ctl;
  logic [DW-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, wb_data;
  logic          alu_zero, take;

  assign f_op  = imem_rdata[31:26];
  assign f_rs  = imem_rdata[25:21];
  assign f_rt  = imem_rdata[20:16];
  assign f_rd  = imem_rdata[15:11];
  assign f_fn  = imem_rdata[5:0];
  assign f_imm = imem_rdata[15:0];

  cpu6_decode u_dec (
    .opcode_i (f_op),
    .funct_i  (f_fn),
    .ctrl_o   (ctl)
  );

  cpu6_immext #(.DW(DW)) u_ext (
    .imm_i    (f_imm),
    .signed_i (ctl.ext_signed),
    .ext_o    (imm_ext)
  );

  assign dst     = ctl.dst_is_rd ? f_rd : f_rt;
  assign wb_data = ctl.wb_from_mem ? dmem_rdata : alu_y;

  cpu6_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .raddr_a_i (f_rs),
    .raddr_b_i (f_rt),
    .rdata_a_o (rs_val),
    .rdata_b_o (rt_val),
    .we_i      (ctl.reg_write),
    .waddr_i   (dst),
    .wdata_i   (wb_data)
  );

  assign alu_b = ctl.src_is_imm ? imm_ext : rt_val;

  cpu6_alu #(.DW(DW)) u_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .op_i   (ctl.alu_op),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  assign take      = ctl.branch & alu_zero;
  assign pc_plus4  = pc_q + DW'(4);
  assign br_target = pc_plus4 + {imm_ext[DW-3:0], 2'b00};
  assign pc_next   = take ? br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_wen   = ctl.mem_write;

  // R1: reset returns the fetch address to zero
  assert_reset_pc_R1: assert property (@(posedge clk)
    rst |=> (imem_addr == '0));

  // R2: sequential flow advances by one word
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    !(ctl.branch && alu_zero) |=> (imem_addr == $past(imem_addr) + DW'(4)));

  // R6: only the store opcode strobes data memory
  assert_wen_store_R6: assert property (@(posedge clk) disable iff (rst)
    dmem_wen |-> (imem_rdata[31:26] == OPC_SW));

  // R7: on a compare the zero flag means the two registers are equal
  assert_eq_flag_R7: assert property (@(posedge clk) disable iff (rst)
    ctl.branch |-> (alu_zero == (rs_val == rt_val)));

  // R4: the OR immediate carries no sign bits
  assert_zext_R4: assert property (@(posedge clk) disable iff (rst)
    (f_op == OPC_ORI) |-> (alu_b[DW-1:16] == '0));

endmodule

// File: tb/cpu6_core_test.sv
`timescale 1ns/1ps
module cpu6_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_wen;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  cpu6_core uut (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_wen   (dmem_wen),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_wen) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] rtype(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] itype(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  typedef struct packed {
    logic [31:0] pc;
    logic        we;
    logic        addr_chk;
    logic [31:0] addr;
    logic [31:0] data;
  } step_t;

  localparam int NSTEP = 18;
  localparam step_t STEPS [NSTEP] = '{
    '{32'h00, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h04, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h08, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h0C, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h10, 1'b1, 1'b1, 32'h10, 32'h00008008},
    '{32'h14, 1'b1, 1'b1, 32'h14, 32'hFFFF7FFE},
    '{32'h18, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h1C, 1'b1, 1'b1, 32'h18, 32'h0},
    '{32'h20, 1'b0, 1'b1, 32'h10, 32'h0},
    '{32'h24, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h28, 1'b0, 1'b1, 32'h10, 32'h0},
    '{32'h2C, 1'b1, 1'b1, 32'h1C, 32'h00008008},
    '{32'h30, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h3C, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h40, 1'b1, 1'b1, 32'h24, 32'h3},
    '{32'h44, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h44, 1'b0, 1'b0, 32'h00, 32'h0},
    '{32'h44, 1'b0, 1'b0, 32'h00, 32'h0}
  };

  task automatic check(input logic ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
    imem[0]  = itype(6'h0D, 0, 1, 16'h8005);    // ori r1 <- 0x8005
    imem[1]  = itype(6'h0D, 0, 2, 16'h0003);    // ori r2 <- 3
    imem[2]  = rtype(1, 2, 3, 6'h21);           // add r3 = r1+r2
    imem[3]  = rtype(2, 1, 4, 6'h23);           // sub r4 = r2-r1
    imem[4]  = itype(6'h2B, 0, 3, 16'h0010);    // sw r3 -> 0x10
    imem[5]  = itype(6'h2B, 0, 4, 16'h0014);    // sw r4 -> 0x14
    imem[6]  = itype(6'h0D, 0, 0, 16'h1234);    // ori r0 (ignored)
    imem[7]  = itype(6'h2B, 0, 0, 16'h0018);    // sw r0 -> 0x18
    imem[8]  = itype(6'h23, 0, 5, 16'h0010);    // lw r5 <- [0x10]
    imem[9]  = itype(6'h0D, 0, 6, 16'h0020);    // ori r6 <- 0x20
    imem[10] = itype(6'h23, 6, 7, 16'hFFF0);    // lw r7 <- [r6-16]
    imem[11] = itype(6'h2B, 0, 7, 16'h001C);    // sw r7 -> 0x1C
    imem[12] = itype(6'h04, 5, 3, 16'h0002);    // beq taken, +2
    imem[13] = itype(6'h2B, 0, 1, 16'h0020);    // skipped
    imem[14] = itype(6'h2B, 0, 1, 16'h0024);    // skipped
    imem[15] = itype(6'h04, 1, 2, 16'h0005);    // beq not taken
    imem[16] = itype(6'h2B, 0, 2, 16'h0024);    // sw r2 -> 0x24
    imem[17] = itype(6'h04, 0, 0, 16'hFFFF);    // beq self-loop

    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(imem_addr == 32'h0, "R1 reset pc", imem_addr, 32'h0);
    check(dmem_wen == 1'b0 || imem_rdata[31:26] == 6'h2B, "R6 no store at reset",
          {31'h0, dmem_wen}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NSTEP; i++) begin
      check(imem_addr == STEPS[i].pc, "R2 R7 fetch address", imem_addr, STEPS[i].pc);
      check(dmem_wen == STEPS[i].we, "R6 store strobe", {31'h0, dmem_wen},
            {31'h0, STEPS[i].we});
      if (STEPS[i].addr_chk)
        check(dmem_addr == STEPS[i].addr, "R5 R6 data address", dmem_addr, STEPS[i].addr);
      if (STEPS[i].we)
        check(dmem_wdata == STEPS[i].data, "R3 R4 R6 store data", dmem_wdata, STEPS[i].data);
      @(posedge clk);
      @(negedge clk);
    end

    check(dmem[4] == 32'h00008008, "R3 R4 add of zero-extended value", dmem[4], 32'h00008008);
    check(dmem[5] == 32'hFFFF7FFE, "R3 subtract wraps", dmem[5], 32'hFFFF7FFE);
    check(dmem[6] == 32'h0, "R8 register zero unchanged", dmem[6], 32'h0);
    check(dmem[7] == 32'h00008008, "R5 load via negative offset", dmem[7], 32'h00008008);
    check(dmem[8] == 32'h0, "R7 taken branch skipped store", dmem[8], 32'h0);
    check(dmem[9] == 32'h3, "R7 not-taken path store", dmem[9], 32'h3);

    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(imem_addr == 32'h0, "R1 reset mid-run", imem_addr, 32'h0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(imem_addr == 32'h4, "R2 first step after reset", imem_addr, 32'h4);

    finish_run();
  end

endmodule